// File: doc/BRIEF.md
# Motor Stall and Command-Clock Watchdog

This block watches a brushless motor drive for two failure conditions. The first is a rotor that never reaches the commanded speed: if the speed-lock flag stays low for the whole stall window while the drive is running, a stall fault is latched. The second is a command clock that has stopped toggling, which is flagged while it lasts. Either fault raises a request that turns off all low-side gate outputs. The block also produces the power-on initialisation interval, during which every drive output is held off.

All timing is counted in pulses of a slow timebase tick (`tick_i`, one clock wide). The stall window is the parameter `STALL_TICKS`. The clock-loss window is derived from it as `STALL_TICKS / CLKLOSS_DIV`, which is 100 ticks with the defaults. The drive state is start/stop at "start" (`stop_i` = 0) and brake released (`brake_i` = 0), outside the initialisation interval.

The stall fault stays latched. It clears only after the operator stops the motor or applies the brake for at least `RELEASE_TICKS` ticks and then returns to drive, or on a reset. The stall timer is frozen while a clock loss, a thermal shutdown or an undervoltage condition is active, so that another protection does not cause a false stall.

Top module: `motor_stall_guard`

## Requirements
- R1: The stall timer and the clock-loss monitor act only in the drive state (`stop_i` = 0 and `brake_i` = 0). Outside it, neither `stall_o` nor `clk_loss_o` can become set.
- R2: In the drive state, with `lock_i` low and no inhibit active, `stall_o` and `low_off_o` go high once `STALL_TICKS` ticks have elapsed. They are still low after `STALL_TICKS`-3 ticks.
- R3: Once set, `stall_o` stays high. It is cleared only when `stop_i` or `brake_i` has been held high for at least `RELEASE_TICKS` ticks and the drive state then returns. A shorter stop or brake interval leaves it set. Asserting `rst_n` low also clears it.
- R4: In the drive state, if no rising edge of `cmd_clk_i` occurs for `STALL_TICKS/CLKLOSS_DIV` ticks, `clk_loss_o` and `low_off_o` go high. `clk_loss_o` returns low within a few clock cycles of the next rising edge.
- R5: While `therm_i`, `uvlo_i` or `clk_loss_o` is high, the stall timer neither advances nor trips.
- R6: For `INIT_TICKS` ticks after reset release, `init_o` is high and `stall_o`, `clk_loss_o` and `low_off_o` are low. After that, `init_o` is low.
- R7: A high `lock_i` restarts the stall timer, so unlocked intervals shorter than the stall window never trip.
- R8: Leaving the drive state restarts the stall timer, so unlocked time does not accumulate across a stop or brake interval.
- R9: The clock-loss counter restarts on every rising edge of the synchronised command clock, so a slow clock with a period below the loss window never raises `clk_loss_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Timebase tick, one clock wide |
| lock_i | input | 1 | Speed-lock flag, 1 = speed within lock range |
| stop_i | input | 1 | Start/stop, 1 = stop, 0 = start |
| brake_i | input | 1 | Brake, 1 = brake applied, 0 = released |
| cmd_clk_i | input | 1 | Asynchronous command clock |
| therm_i | input | 1 | Thermal shutdown active |
| uvlo_i | input | 1 | Undervoltage lockout active |
| stall_o | output | 1 | Latched stall fault |
| clk_loss_o | output | 1 | Command clock lost |
| low_off_o | output | 1 | Request to turn off all low-side outputs |
| init_o | output | 1 | Initialisation interval, all drive outputs forced off |

## Verification
The bench targets the edges of each window. It checks that the stall window is neither short nor long by a few ticks. It checks that stop or brake pulses just below and above the release length clear the latch or leave it set, with random lengths. A design that cleared on any stop toggle, or that counted the stop interval wrongly, would show a stall flag of the wrong value after the pulse. It checks that random lock pulses and a short brake each restart the timer, since a timer that only paused would trip early. It checks that thermal, undervoltage and clock-loss inhibits freeze the timer, and that a slow but live command clock never raises clock loss, which a counter that failed to restart on edges would do.

// File: rtl/stall_guard_pkg.sv
package stall_guard_pkg;

  // Width of a counter that must hold values 0..maxval
  function automatic int unsigned cnt_width(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

  // Clock-loss window derived from the stall window, never below one tick
  function automatic int unsigned loss_window(input int unsigned stall_ticks,
                                              input int unsigned divider);
    int unsigned w;
    w = stall_ticks / divider;
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/sg_reset_init.sv
module sg_reset_init
  import stall_guard_pkg::*;
#(
  parameter int unsigned INIT_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic rst_sync_no,
  output logic init_o
);

  localparam int unsigned IW = cnt_width(INIT_TICKS);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_TICKS - 1);

  // Reset synchroniser: assert immediately, release after two edges
  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end

  assign rst_sync_no = rs_q[1];

  // Initialisation interval counter
  logic [IW-1:0] cnt_q, cnt_d;
  logic          init_q, init_d;

  always_comb begin
    cnt_d  = cnt_q;
    init_d = init_q;
    if (init_q && tick_i) begin
      if (cnt_q == INIT_LAST) begin
        init_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_no) begin
    if (!rst_sync_no) begin
      cnt_q  <= '0;
      init_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      init_q <= init_d;
    end
  end

  assign init_o = init_q;

endmodule

// File: rtl/sg_clk_loss.sv
module sg_clk_loss
  import stall_guard_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOSS_TICKS  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_clk_i,
  input  logic tick_i,
  input  logic drive_i,
  output logic loss_o
);

  localparam int unsigned LW = cnt_width(LOSS_TICKS);
  localparam logic [LW-1:0] LOSS_MAX = LW'(LOSS_TICKS);

  // Synchroniser chain, depth chosen by parameter
  logic [SYNC_STAGES-1:0] sync_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= cmd_clk_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  logic prev_q;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  // Ticks since the last rising edge, saturating at the window
  logic [LW-1:0] cnt_q, cnt_d;
  logic          loss_q, loss_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!drive_i || rise) begin
      cnt_d = '0;
    end else if (tick_i && (cnt_q != LOSS_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
    loss_d = drive_i & ~rise & (cnt_q == LOSS_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      loss_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      loss_q <= loss_d;
    end
  end

  assign loss_o = loss_q;

endmodule

// File: rtl/sg_release.sv
module sg_release
  import stall_guard_pkg::*;
#(
  parameter int unsigned RELEASE_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic drive_i,
  output logic clr_o
);

  localparam int unsigned RW = cnt_width(RELEASE_TICKS);
  localparam logic [RW-1:0] REL_MAX = RW'(RELEASE_TICKS);

  logic [RW-1:0] cnt_q, cnt_d;
  logic          clr_q, clr_d;

  // Measure the length of each stop/brake interval; pulse a clear
  // on return to drive when it was long enough.
  always_comb begin
    cnt_d = cnt_q;
    clr_d = 1'b0;
    if (!drive_i) begin
      if (tick_i && (cnt_q != REL_MAX)) begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      clr_d = (cnt_q == REL_MAX);
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clr_q <= clr_d;
    end
  end

  assign clr_o = clr_q;

endmodule

// File: rtl/sg_stall.sv
module sg_stall
  import stall_guard_pkg::*;
#(
  parameter int unsigned STALL_TICKS = 3400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic drive_i,
  input  logic lock_i,
  input  logic inhibit_i,
  input  logic clr_i,
  output logic stall_o
);

  localparam int unsigned SW = cnt_width(STALL_TICKS);
  localparam logic [SW-1:0] STALL_LAST = SW'(STALL_TICKS - 1);

  logic [SW-1:0] cnt_q, cnt_d;
  logic          stall_q, stall_d;

  always_comb begin
    cnt_d   = cnt_q;
    stall_d = stall_q;
    if (!drive_i || lock_i) begin
      cnt_d = '0;
    end else if (tick_i && !inhibit_i && !stall_q) begin
      if (cnt_q == STALL_LAST) begin
        cnt_d   = '0;
        stall_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (clr_i) begin
      stall_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stall_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      stall_q <= stall_d;
    end
  end

  assign stall_o = stall_q;

endmodule

// File: rtl/motor_stall_guard.sv
module motor_stall_guard
  import stall_guard_pkg::*;
#(
  parameter int unsigned STALL_TICKS   = 3400,
  parameter int unsigned CLKLOSS_DIV   = 34,
  parameter int unsigned RELEASE_TICKS = 2,
  parameter int unsigned INIT_TICKS    = 16,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic lock_i,
  input  logic stop_i,
  input  logic brake_i,
  input  logic cmd_clk_i,
  input  logic therm_i,
  input  logic uvlo_i,
  output logic stall_o,
  output logic clk_loss_o,
  output logic low_off_o,
  output logic init_o
);

  localparam int unsigned LOSS_TICKS = loss_window(STALL_TICKS, CLKLOSS_DIV);

  logic rst_sync_n;
  logic init_w;
  logic drive_w;
  logic loss_w;
  logic stall_w;
  logic clr_w;
  logic inhibit_w;

  sg_reset_init #(.INIT_TICKS(INIT_TICKS)) u_init (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .rst_sync_no (rst_sync_n),
    .init_o      (init_w)
  );

  assign drive_w   = ~stop_i & ~brake_i & ~init_w;
  assign inhibit_w = loss_w | therm_i | uvlo_i;

  sg_clk_loss #(
    .SYNC_STAGES (SYNC_STAGES),
    .LOSS_TICKS  (LOSS_TICKS)
  ) u_loss (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_clk_i (cmd_clk_i),
    .tick_i    (tick_i),
    .drive_i   (drive_w),
    .loss_o    (loss_w)
  );

  sg_release #(.RELEASE_TICKS(RELEASE_TICKS)) u_rel (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_i  (tick_i),
    .drive_i (drive_w),
    .clr_o   (clr_w)
  );

  sg_stall #(.STALL_TICKS(STALL_TICKS)) u_stall (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick_i    (tick_i),
    .drive_i   (drive_w),
    .lock_i    (lock_i),
    .inhibit_i (inhibit_w),
    .clr_i     (clr_w),
    .stall_o   (stall_w)
  );

  assign stall_o    = stall_w;
  assign clk_loss_o = loss_w;
  assign low_off_o  = stall_w | loss_w;
  assign init_o     = init_w;

endmodule

// File: rtl/motor_stall_guard_chk.sv
module motor_stall_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic lock_i,
  input logic stop_i,
  input logic brake_i,
  input logic therm_i,
  input logic uvlo_i,
  input logic stall_o,
  input logic clk_loss_o,
  input logic low_off_o,
  input logic init_o
);

  // R1: clock loss only ever reported after a cycle in the drive state
  p_loss_in_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clk_loss_o |-> $past(!stop_i && !brake_i));

  // R2: a stall trips only from the drive state
  p_trip_in_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_o) |-> $past(!stop_i && !brake_i && !init_o));

  // R3: the latch falls only once drive has been restored
  p_clear_on_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_o) |-> $past(!stop_i && !brake_i, 2));

  // R4: a lost clock requests low-side turn-off
  p_loss_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_loss_o |-> low_off_o);

  // R5: no trip while another protection is active
  p_inhibit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_o) |-> $past(!therm_i && !uvlo_i && !clk_loss_o));

  // R6: outputs quiet during the initialisation interval
  p_init_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    init_o |-> (!stall_o && !clk_loss_o && !low_off_o));

  // R7: no trip in a cycle where the lock flag was high
  p_lock_no_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_o) |-> $past(!lock_i));

endmodule

bind motor_stall_guard motor_stall_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lock_i     (lock_i),
  .stop_i     (stop_i),
  .brake_i    (brake_i),
  .therm_i    (therm_i),
  .uvlo_i     (uvlo_i),
  .stall_o    (stall_o),
  .clk_loss_o (clk_loss_o),
  .low_off_o  (low_off_o),
  .init_o     (init_o)
);

// File: tb/sim_motor_stall_guard.sv
`timescale 1ns/1ps
module sim_motor_stall_guard;

  localparam int STALL = 340;
  localparam int DIV   = 34;
  localparam int CL    = STALL / DIV;
  localparam int REL   = 3;
  localparam int INIT  = 4;
  localparam int TDIV  = 4;

  logic clk = 1'b0;
  logic rst_n, tick, lock, stop, brake, cmd_clk, therm, uvlo;
  logic stall_o, clk_loss_o, low_off_o, init_o;

  int checks = 0;
  int fails  = 0;
  bit cc_en  = 1'b0;
  int cc_half = 3;
  int hc = 0;
  int tcnt = 0;
  bit reported = 1'b0;

  always #4 clk = ~clk;

  motor_stall_guard #(
    .STALL_TICKS   (STALL),
    .CLKLOSS_DIV   (DIV),
    .RELEASE_TICKS (REL),
    .INIT_TICKS    (INIT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .lock_i(lock), .stop_i(stop),
    .brake_i(brake), .cmd_clk_i(cmd_clk), .therm_i(therm), .uvlo_i(uvlo),
    .stall_o(stall_o), .clk_loss_o(clk_loss_o), .low_off_o(low_off_o),
    .init_o(init_o)
  );

  // timebase tick: one pulse every TDIV cycles
  initial begin
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tcnt = (tcnt == TDIV - 1) ? 0 : tcnt + 1;
      tick = (tcnt == 0);
    end
  end

  // command clock
  initial begin
    cmd_clk = 1'b0;
    forever begin
      @(negedge clk);
      if (cc_en) begin
        hc++;
        if (hc >= cc_half) begin
          cmd_clk = ~cmd_clk;
          hc = 0;
        end
      end
    end
  end

  function automatic bit exp_stall(input int unlocked_ticks);
    return unlocked_ticks >= STALL;
  endfunction

  function automatic bit exp_cleared(input int stop_ticks);
    return stop_ticks >= REL;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n * TDIV) @(negedge clk);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(3);
    chk("R3 reset clears stall", stall_o, 1'b0);
    rst_n = 1'b1;
    cyc(3);
    chk("R6 init high after reset", init_o, 1'b1);
    chk("R6 low_off quiet in init", low_off_o, 1'b0);
    wt(INIT + 2);
    chk("R6 init ends", init_o, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; lock = 1'b0; stop = 1'b1; brake = 1'b1;
    therm = 1'b0; uvlo = 1'b0;
    cyc(5);
    chk("R6 stall low in reset", stall_o, 1'b0);
    chk("R6 clk_loss low in reset", clk_loss_o, 1'b0);
    do_reset();

    // R1: stopped / braked, no clock, unlocked: nothing fires
    cc_en = 1'b0; stop = 1'b1; brake = 1'b0;
    wt(STALL + 10);
    chk("R1 no stall while stopped", stall_o, 1'b0);
    chk("R1 no clk_loss while stopped", clk_loss_o, 1'b0);
    stop = 1'b0; brake = 1'b1;
    wt(CL + 5);
    chk("R1 no clk_loss while braked", clk_loss_o, 1'b0);

    // R2: stall window edges
    cc_en = 1'b1; brake = 1'b0;
    wt(STALL - 3);
    chk("R2 stall not early", stall_o, exp_stall(STALL - 3));
    wt(6);
    chk("R2 stall trips", stall_o, exp_stall(STALL + 3));
    chk("R2 low_off on stall", low_off_o, 1'b1);

    // R3: short brake keeps latch, long stop clears
    brake = 1'b1; wt(1); brake = 1'b0; cyc(3);
    chk("R3 short brake keeps stall", stall_o, 1'b1);
    stop = 1'b1; wt(REL + 3); stop = 1'b0; cyc(3);
    chk("R3 long stop clears stall", stall_o, 1'b0);
    wt(STALL + 3);
    chk("R2 retrip", stall_o, 1'b1);
    brake = 1'b1; wt(REL + 1); brake = 1'b0; cyc(3);
    chk("R3 long brake clears stall", stall_o, 1'b0);
    wt(STALL + 3);
    chk("R2 retrip before reset", stall_o, 1'b1);
    do_reset();

    // R3: random release lengths
    for (int i = 0; i < 5; i++) begin
      int len;
      wt(STALL + 3);
      chk("R2 trip in release loop", stall_o, 1'b1);
      len = $urandom_range(8, 1);
      if (len == REL) len = REL + 1;
      stop = 1'b1; wt(len); stop = 1'b0; cyc(3);
      chk("R3 random release", stall_o, !exp_cleared(len));
      if (stall_o) begin
        stop = 1'b1; wt(REL + 2); stop = 1'b0; cyc(3);
        chk("R3 follow-up release", stall_o, 1'b0);
      end
    end

    // R4: clock loss window and recovery
    lock = 1'b1;
    cc_en = 1'b0;
    wt(CL - 3);
    chk("R4 no early clk_loss", clk_loss_o, 1'b0);
    wt(6);
    chk("R4 clk_loss set", clk_loss_o, 1'b1);
    chk("R4 low_off on clk_loss", low_off_o, 1'b1);
    cc_en = 1'b1;
    cyc(16);
    chk("R4 clk_loss clears on edge", clk_loss_o, 1'b0);

    // R9: slow but live clock never flags loss
    begin
      int bad;
      bad = 0;
      cc_half = 14;
      for (int k = 0; k < 40 * TDIV; k++) begin
        @(negedge clk);
        if (clk_loss_o) bad++;
      end
      chk("R9 slow clock restarts counter", bad == 0, 1'b1);
      cc_half = 3;
    end

    // R5: inhibits freeze the stall timer
    therm = 1'b1; lock = 1'b0;
    wt(STALL + 10);
    chk("R5 thermal inhibits stall", stall_o, 1'b0);
    lock = 1'b1; cyc(2); therm = 1'b0; uvlo = 1'b1; lock = 1'b0;
    wt(STALL + 10);
    chk("R5 undervoltage inhibits stall", stall_o, 1'b0);
    lock = 1'b1; cyc(2); uvlo = 1'b0; cc_en = 1'b0; lock = 1'b0;
    wt(STALL + 10);
    chk("R5 clk_loss present", clk_loss_o, 1'b1);
    chk("R5 clk_loss inhibits stall", stall_o, 1'b0);
    lock = 1'b1; cc_en = 1'b1; cyc(16);

    // R7: random lock pulses below the window
    lock = 1'b0;
    for (int i = 0; i < 6; i++) begin
      int gap;
      gap = $urandom_range(STALL - 5, STALL / 2);
      wt(gap);
      lock = 1'b1; wt(1); lock = 1'b0;
      chk("R7 lock restarts timer", stall_o, 1'b0);
    end

    // R8: leaving drive restarts the timer
    lock = 1'b1; cyc(2); lock = 1'b0;
    wt(STALL - 20);
    brake = 1'b1; wt(1); brake = 1'b0;
    wt(STALL - 20);
    chk("R8 brake restarts timer", stall_o, 1'b0);
    wt(25);
    chk("R8 trips after full window", stall_o, exp_stall(STALL + 5));

    report();
    $finish;
  end

endmodule